// File: doc/BRIEF.md
# Parallel Flash Query Probe Sequencer

This block runs on the host side of an asynchronous parallel flash bus. When it receives a start strobe, it checks whether a device that answers query commands sits at a given base address. If one does, it reads the device's geometry table and its identification codes. All bus traffic goes through a simple synchronous request port. Each request, read or write, is held until the memory side raises `mem_ready`.

Every command and query offset is multiplied by a scale factor before it is added to the base address. The scale factor is the interleave times the device width in bytes. The probe runs these phases in order:

1. Two reset commands.
2. A query-entry command.
3. A three-character signature check.
4. A read of the erase-region count.
5. Capture of the query table into a 64-byte buffer.
6. An identification-entry sequence and two 16-bit code reads.
7. A final pair of reset commands that returns the device to read-array mode.

Software reads the captured bytes back through a byte-select port once `done` pulses.

Top module: `flash_query_probe`

## Requirements
- R1: After reset: `mem_req`, `done` and `present` are 0, `status` is 0, and `mfr_id`, `dev_id` and `region_cnt` are 0.
- R2: If `base_addr` + 0xFF, computed without wrap-around, is at or above `MAP_SIZE`, a start makes no bus request. In that case `done` pulses one cycle after start is sampled, with `status` = 2 and `present` = 0.
- R3: Once `mem_req` is high, `mem_addr`, `mem_we` and `mem_wdata` stay unchanged until the cycle in which `mem_ready` is sampled high. A transfer completes in exactly that cycle.
- R4: Every bus address is `base_addr` + offset × `scale`. A probe opens with these transfers:
  - write 0xF0 at offset 0;
  - write 0xFF at offset 0;
  - write 0x98 at offset 0x55;
  - read offset 0x10. Command bytes are carried in `mem_wdata[7:0]`.
- R5: The signature is 'Q' (0x51), 'R' (0x52) and 'Y' (0x59), read in the low byte at offsets 0x10, 0x11 and 0x12. At the first mismatch, no further reads are made. The block then writes 0xF0 and 0xFF at offset 0 and ends with `status` = 1 and `present` = 0.
- R6: After a good signature the block reads the region count from the low byte at offset 0x2C. If the count is zero, it writes 0xF0 and 0xFF at offset 0 and ends with `status` = 3, `present` = 1 and `region_cnt` = 0.
- R7: If 29 + 4 × count exceeds 64, the block writes 0xF0 and 0xFF at offset 0 and ends with `status` = 4, `present` = 1 and `region_cnt` set to the count.
- R8: Otherwise, 29 + 4 × count bytes are read from offsets 0x10 upward. Buffer entry i holds the low byte read at offset 0x10 + i. Entries that were not captured in the current probe read 0 through `qbuf_sel`/`qbuf_data`.
- R9: After the table capture the block performs these transfers in order:
  - write 0xF0 at offset 0;
  - write 0xAA at offset 0x555;
  - write 0x55 at offset 0x2AA;
  - write 0x90 at offset 0x555;
  - read offset 0 into `mfr_id` (16 bits);
  - read offset 1 into `dev_id` (16 bits);
  - write 0xF0 at offset 0;
  - write 0xFF at offset 0.

  It then ends with `status` = 0 and `present` = 1.
- R10: `done` is high for exactly one cycle, and `mem_req` is low in that cycle. A start that arrives during a probe is ignored, as are changes to `base_addr` or `scale` during a probe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a probe (sampled while idle) |
| base_addr | input | ADDR_W | Base address of the device |
| scale | input | SCALE_W | Interleave × device width in bytes |
| mem_req | output | 1 | Bus request valid |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Bus address |
| mem_wdata | output | DATA_W | Write data (command in low byte) |
| mem_rdata | input | DATA_W | Read data, valid with `mem_ready` |
| mem_ready | input | 1 | Transfer completes this cycle |
| done | output | 1 | One-cycle completion pulse |
| present | output | 1 | Signature found |
| status | output | 3 | 0 ok, 1 absent, 2 out of range, 3 no regions, 4 overflow |
| mfr_id | output | 16 | Manufacturer code |
| dev_id | output | 16 | Device code |
| region_cnt | output | 8 | Erase-region count read |
| qbuf_sel | input | SEL_W | Captured byte select |
| qbuf_data | output | 8 | Captured byte at `qbuf_sel` |

## Verification
The bench builds the block with a 16-bit address, scale factors of 1, 2, 4 and 8, and a map size of 0x4000. With the small map size, the range boundary can be tested directly: base 0x3F00 is accepted, and bases 0x3F01, 0x4000 and 0xFFFF are rejected. The 0xFFFF case checks that the range sum does not wrap. Region counts are swept from 0 to 9, plus 255, at every scale. This covers the zero-region exit, every table length that fits, the first count that overflows the 64-byte buffer, and a count whose product needs more than 8 bits. A memory model with varying response latency tracks the query and identification modes. A signature corruption is injected at each of the three characters in turn.

// File: rtl/flash_query_probe.sv
module flash_query_probe #(
  parameter int          ADDR_W   = 24,
  parameter int          DATA_W   = 16,
  parameter int          SCALE_W  = 4,
  parameter int unsigned MAP_SIZE = 32'h0010_0000,
  parameter int          HDR_LEN  = 29,
  parameter int          BUF_LEN  = 64,
  localparam int         SEL_W    = $clog2(BUF_LEN),
  localparam int         IDX_W    = $clog2(BUF_LEN + 1),
  localparam int         PROD_W   = 12 + SCALE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [ADDR_W-1:0]  base_addr,
  input  logic [SCALE_W-1:0] scale,
  output logic               mem_req,
  output logic               mem_we,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic [DATA_W-1:0]  mem_wdata,
  input  logic [DATA_W-1:0]  mem_rdata,
  input  logic               mem_ready,
  output logic               done,
  output logic               present,
  output logic [2:0]         status,
  output logic [15:0]        mfr_id,
  output logic [15:0]        dev_id,
  output logic [7:0]         region_cnt,
  input  logic [SEL_W-1:0]   qbuf_sel,
  output logic [7:0]         qbuf_data
);

  localparam logic [2:0] ST_OK = 3'd0, ST_ABSENT = 3'd1, ST_RANGE = 3'd2,
                         ST_NOREG = 3'd3, ST_OVF = 3'd4;
  localparam logic [3:0] STEP_EXIT = 4'd14;

  logic               busy;
  logic [3:0]         step;
  logic [IDX_W-1:0]   idx, tbl_len;
  logic [2:0]         pend;
  logic [ADDR_W-1:0]  base_r;
  logic [SCALE_W-1:0] scale_r;
  logic [7:0]         qbuf [BUF_LEN];

  logic        op_we;
  logic [11:0] op_off;
  logic [7:0]  op_cmd;
  logic [7:0]  sig_ch;

  always_comb begin
    op_we  = 1'b1;
    op_off = 12'h000;
    op_cmd = 8'hF0;
    sig_ch = 8'h51;
    case (step)
      4'd1:  op_cmd = 8'hFF;
      4'd2:  begin op_off = 12'h055; op_cmd = 8'h98; end
      4'd3:  begin op_we = 1'b0; op_off = 12'h010; end
      4'd4:  begin op_we = 1'b0; op_off = 12'h011; sig_ch = 8'h52; end
      4'd5:  begin op_we = 1'b0; op_off = 12'h012; sig_ch = 8'h59; end
      4'd6:  begin op_we = 1'b0; op_off = 12'h02C; end
      4'd7:  begin op_we = 1'b0; op_off = 12'h010 + 12'(idx); end
      4'd9:  begin op_off = 12'h555; op_cmd = 8'hAA; end
      4'd10: begin op_off = 12'h2AA; op_cmd = 8'h55; end
      4'd11: begin op_off = 12'h555; op_cmd = 8'h90; end
      4'd12: op_we = 1'b0;
      4'd13: begin op_we = 1'b0; op_off = 12'h001; end
      4'd15: op_cmd = 8'hFF;
      default: ;
    endcase
  end

  logic [PROD_W-1:0] prod;
  assign prod      = PROD_W'(op_off) * PROD_W'(scale_r);
  assign mem_req   = busy;
  assign mem_we    = op_we;
  assign mem_addr  = base_r + ADDR_W'(prod);
  assign mem_wdata = DATA_W'(op_cmd);
  assign qbuf_data = qbuf[qbuf_sel];

  wire [7:0]  rd8   = mem_rdata[7:0];
  wire [10:0] need  = 11'(HDR_LEN) + {1'b0, rd8, 2'b00};
  wire        oor   = (33'(base_addr) + 33'd255) >= 33'(MAP_SIZE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; step <= '0; idx <= '0; tbl_len <= '0; pend <= ST_OK;
      base_r <= '0; scale_r <= '0; done <= 1'b0; present <= 1'b0;
      status <= ST_OK; mfr_id <= '0; dev_id <= '0; region_cnt <= '0;
      for (int i = 0; i < BUF_LEN; i++) qbuf[i] <= 8'h00;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          base_r <= base_addr; scale_r <= scale;
          present <= 1'b0; mfr_id <= '0; dev_id <= '0; region_cnt <= '0;
          for (int i = 0; i < BUF_LEN; i++) qbuf[i] <= 8'h00;
          if (oor) begin
            status <= ST_RANGE; done <= 1'b1;
          end else begin
            busy <= 1'b1; step <= '0; pend <= ST_OK;
          end
        end
      end else if (mem_ready) begin
        case (step)
          4'd3, 4'd4, 4'd5: begin
            if (rd8 != sig_ch) begin
              pend <= ST_ABSENT; step <= STEP_EXIT;
            end else begin
              step <= step + 4'd1;
              if (step == 4'd5) present <= 1'b1;
            end
          end
          4'd6: begin
            region_cnt <= rd8;
            if (rd8 == 8'd0) begin
              pend <= ST_NOREG; step <= STEP_EXIT;
            end else if (need > 11'(BUF_LEN)) begin
              pend <= ST_OVF; step <= STEP_EXIT;
            end else begin
              tbl_len <= IDX_W'(need); idx <= '0; step <= 4'd7;
            end
          end
          4'd7: begin
            qbuf[SEL_W'(idx)] <= rd8;
            if (idx == tbl_len - 1'b1) step <= 4'd8;
            else idx <= idx + 1'b1;
          end
          4'd12: begin mfr_id <= mem_rdata[15:0]; step <= 4'd13; end
          4'd13: begin dev_id <= mem_rdata[15:0]; step <= 4'd14; end
          4'd15: begin busy <= 1'b0; done <= 1'b1; status <= pend; end
          default: step <= step + 4'd1;
        endcase
      end
    end
  end

endmodule

module flash_query_probe_chk #(
  parameter int          ADDR_W   = 24,
  parameter int          DATA_W   = 16,
  parameter int          SCALE_W  = 4,
  parameter int unsigned MAP_SIZE = 32'h0010_0000,
  parameter int          HDR_LEN  = 29,
  parameter int          BUF_LEN  = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [ADDR_W-1:0] base_addr,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              mem_ready,
  input logic              done,
  input logic              present,
  input logic [2:0]        status,
  input logic [7:0]        region_cnt
);

  wire bad_base = (33'(base_addr) + 33'd255) >= 33'(MAP_SIZE);

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))); // R3
  AST_RANGE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_req && start && bad_base) |=> (!mem_req && done && status == 3'd2)); // R2
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_req); // R10
  AST_ABSENT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (done && status == 3'd1) |-> !present); // R5
  AST_NOREG_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (done && status == 3'd3) |-> (present && region_cnt == 8'd0)); // R6
  AST_OVF_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (done && status == 3'd4) |-> (HDR_LEN + 4 * int'(region_cnt) > BUF_LEN)); // R7
  AST_OK_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
    (done && status == 3'd0) |-> present); // R9

endmodule

bind flash_query_probe flash_query_probe_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SCALE_W(SCALE_W),
  .MAP_SIZE(MAP_SIZE), .HDR_LEN(HDR_LEN), .BUF_LEN(BUF_LEN)
) chk (.*);

// File: tb/flash_query_probe_test.sv
module flash_query_probe_test;

  localparam int AW = 16;
  localparam int DW = 16;
  localparam int SW = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n = 1'b0, start = 1'b0;
  logic [AW-1:0] base_addr = '0;
  logic [SW-1:0] scale = 4'd1;
  logic          mem_req, mem_we, mem_ready = 1'b0;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata = '0;
  logic          done, present;
  logic [2:0]    status;
  logic [15:0]   mfr_id, dev_id;
  logic [7:0]    region_cnt;
  logic [5:0]    qbuf_sel = '0;
  logic [7:0]    qbuf_data;

  flash_query_probe #(.ADDR_W(AW), .DATA_W(DW), .SCALE_W(SW), .MAP_SIZE(32'h4000),
                      .HDR_LEN(29), .BUF_LEN(64)) uut (.*);

  int checks = 0, fails = 0;

  task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  logic [15:0] cur_base;
  int cur_scale, cur_n, cur_bad, run_id;
  int mode, wcnt, txn, nlog, hold_err;
  bit tracking;
  logic [15:0] h_addr, h_data;
  logic h_we;
  logic        lg_we [128];
  logic [15:0] lg_addr [128];
  logic [7:0]  lg_data [128];
  logic        e_we [128];
  logic [15:0] e_addr [128];
  logic [7:0]  e_data [128];
  int nexp;

  function automatic logic [7:0] qb(input logic [15:0] off);
    logic [7:0] v;
    v = 8'((off * 13 + 5) & 16'hFF);
    if (off == 16'h10) v = (cur_bad == 1) ? ~8'h51 : 8'h51;
    if (off == 16'h11) v = (cur_bad == 2) ? ~8'h52 : 8'h52;
    if (off == 16'h12) v = (cur_bad == 3) ? ~8'h59 : 8'h59;
    if (off == 16'h2C) v = 8'(cur_n);
    return v;
  endfunction

  function automatic logic [15:0] mfr_val();
    return 16'h00C2 ^ 16'(run_id);
  endfunction
  function automatic logic [15:0] dev_val();
    return 16'h22DA + 16'(run_id);
  endfunction

  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ready = 1'b0; wcnt = 0; tracking = 1'b0;
    end else if (mem_ready) begin
      mem_ready = 1'b0;
      tracking = 1'b0;
    end else if (mem_req) begin
      if (!tracking) begin
        tracking = 1'b1; h_addr = mem_addr; h_we = mem_we; h_data = mem_wdata;
      end else if (h_addr != mem_addr || h_we != mem_we || h_data != mem_wdata) hold_err++;
      if (wcnt >= txn % 3) begin
        logic [15:0] off;
        wcnt = 0;
        off = 16'(mem_addr - cur_base);
        off = off / 16'(cur_scale);
        if (nlog < 128) begin
          lg_we[nlog] = mem_we; lg_addr[nlog] = mem_addr;
          lg_data[nlog] = mem_we ? mem_wdata[7:0] : 8'h00;
        end
        nlog++;
        txn++;
        if (mem_we) begin
          case (mem_wdata[7:0])
            8'h98: if (off == 16'h55) mode = 1;
            8'h90: mode = 2;
            8'hF0, 8'hFF: mode = 0;
            default: ;
          endcase
        end else begin
          case (mode)
            1: mem_rdata = {8'hA5, qb(off)};
            2: mem_rdata = (off == 0) ? mfr_val() : (off == 1) ? dev_val() : 16'h0000;
            default: mem_rdata = 16'hFFFF;
          endcase
        end
        mem_ready = 1'b1;
      end else wcnt++;
    end
  end

  task automatic push(input bit we, input int off, input logic [7:0] d);
    e_we[nexp] = we;
    e_addr[nexp] = 16'(cur_base + off * cur_scale);
    e_data[nexp] = d;
    nexp++;
  endtask

  task automatic build_expected();
    nexp = 0;
    push(1, 0, 8'hF0); push(1, 0, 8'hFF); push(1, 'h55, 8'h98);
    for (int k = 0; k < 3; k++) begin
      push(0, 'h10 + k, 8'h00);
      if (cur_bad == k + 1) begin push(1, 0, 8'hF0); push(1, 0, 8'hFF); return; end
    end
    push(0, 'h2C, 8'h00);
    if (cur_n == 0 || 29 + 4 * cur_n > 64) begin push(1, 0, 8'hF0); push(1, 0, 8'hFF); return; end
    for (int i = 0; i < 29 + 4 * cur_n; i++) push(0, 'h10 + i, 8'h00);
    push(1, 0, 8'hF0); push(1, 'h555, 8'hAA); push(1, 'h2AA, 8'h55); push(1, 'h555, 8'h90);
    push(0, 0, 8'h00); push(0, 1, 8'h00); push(1, 0, 8'hF0); push(1, 0, 8'hFF);
  endtask

  task automatic run_case(input logic [15:0] b, input int s, input int n, input int bad, input bit disturb);
    int cyc, mism, exp_st, len;
    string tag;
    bit ok_run;
    run_id++;
    cur_base = b; cur_scale = s; cur_n = n; cur_bad = bad;
    nlog = 0; mode = 0; hold_err = 0;
    build_expected();
    base_addr = b; scale = SW'(s); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (!done && cyc < 5000) begin
      @(negedge clk);
      cyc++;
      if (disturb && cyc == 5) begin base_addr = 16'h0100; scale = 4'd1; start = 1'b1; end
      if (disturb && cyc == 6) start = 1'b0;
    end
    len = 29 + 4 * n;
    ok_run = (bad == 0) && (n != 0) && (len <= 64);
    exp_st = (bad != 0) ? 1 : (n == 0) ? 3 : (len > 64) ? 4 : 0;
    tag = (bad != 0) ? "R5" : (n == 0) ? "R6" : (len > 64) ? "R7" : "R8";
    mism = (nlog != nexp) ? 1 : 0;
    for (int i = 0; i < nexp && i < nlog && i < 128; i++)
      if (lg_we[i] != e_we[i] || lg_addr[i] != e_addr[i] || lg_data[i] != e_data[i]) mism++;
    check(done == 1'b1, tag, "done seen", int'(done), 1);
    check(nlog == nexp, tag, "transfer count", nlog, nexp);
    check(mism == 0, disturb ? "R10" : tag, "trace mismatches", mism, 0);
    check(lg_we[0] == 1 && lg_data[0] == 8'hF0 && lg_data[1] == 8'hFF && lg_data[2] == 8'h98 &&
          lg_addr[2] == 16'(b + 'h55 * s) && lg_we[3] == 0 && lg_addr[3] == 16'(b + 'h10 * s),
          "R4", "opening sequence", int'(lg_addr[2]), int'(16'(b + 'h55 * s)));
    check(hold_err == 0, "R3", "request held stable", hold_err, 0);
    check(int'(status) == exp_st, tag, "status", int'(status), exp_st);
    check(present == (bad == 0), tag, "present", int'(present), int'(bad == 0));
    check(int'(region_cnt) == ((bad != 0) ? 0 : n), tag, "region_cnt", int'(region_cnt), (bad != 0) ? 0 : n);
    if (ok_run) begin
      check(mfr_id == mfr_val(), "R9", "mfr_id", int'(mfr_id), int'(mfr_val()));
      check(dev_id == dev_val(), "R9", "dev_id", int'(dev_id), int'(dev_val()));
    end else
      check(mfr_id == 0 && dev_id == 0, tag, "ids untouched", int'(mfr_id), 0);
    mism = 0;
    for (int i = 0; i < 64; i++) begin
      logic [7:0] eb;
      eb = (ok_run && i < len) ? qb(16'('h10 + i)) : 8'h00;
      qbuf_sel = 6'(i);
      #0.1;
      if (qbuf_data != eb) mism++;
    end
    check(mism == 0, "R8", "buffer contents", mism, 0);
    @(negedge clk);
    check(done == 1'b0, "R10", "done single cycle", int'(done), 0);
    repeat (2) @(negedge clk);
  endtask

  task automatic range_case(input logic [15:0] b);
    nlog = 0;
    base_addr = b; scale = 4'd2; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(done == 1'b1, "R2", "done one cycle after start", int'(done), 1);
    check(status == 3'd2 && present == 1'b0, "R2", "range status", int'(status), 2);
    @(negedge clk);
    check(done == 1'b0, "R10", "range done single cycle", int'(done), 0);
    repeat (3) @(negedge clk);
    check(nlog == 0, "R2", "no bus transfers", nlog, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    run_id = 0; txn = 0; nlog = 0; hold_err = 0;
    cur_base = 0; cur_scale = 1; cur_n = 0; cur_bad = 0;
    repeat (3) @(negedge clk);
    check(mem_req == 0 && done == 0 && present == 0, "R1", "reset controls", int'({mem_req, done, present}), 0);
    check(status == 0 && mfr_id == 0 && dev_id == 0 && region_cnt == 0, "R1", "reset values",
          int'(status) + int'(mfr_id) + int'(region_cnt), 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int si = 0; si < 4; si++)
      for (int n = 0; n <= 10; n++)
        run_case(16'(16'h0400 * (si + 1) + 16'(n * 16)), 1 << si, (n == 10) ? 255 : n, 0, 1'b0);
    for (int k = 1; k <= 3; k++) run_case(16'h1200, 2, 4, k, 1'b0);
    run_case(16'h3F00, 4, 2, 0, 1'b0);
    run_case(16'h0800, 2, 8, 0, 1'b1);
    range_case(16'h3F01);
    range_case(16'h4000);
    range_case(16'hFFFF);
    run_case(16'h0000, 1, 1, 0, 1'b0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule